// File: doc/BRIEF.md
# ADC Trigger and Transfer-Mode Controller

This block sits between a byte-wide host register port and an analog-to-digital converter. The host writes a mode byte. That byte picks one of three pairings of start source and completion method: a host write with polled completion, a periodic pacer tick with an interrupt, or a pacer tick with a DMA request. Every other mode value shuts the block down.

In polled mode a conversion starts when the host writes any byte to the trigger offset. The write produces one start pulse of a single clock. The host then polls a ready bit in the status byte. That bit reads 1 while a conversion runs and drops to 0 when the converter reports end-of-conversion. In the two pacer modes an external tick starts each conversion. Completion raises an interrupt, which a read of the low data byte clears, or a DMA request, which the DMA acknowledge clears.

Top module: `adc_tc_top`

## Requirements
- R1: The mode byte is written at offset 0xB and resets to 0x00. The value 0x01 selects host-write start with polling. The value 0x06 selects pacer start with interrupt. The value 0x02 selects pacer start with DMA.
- R2: In mode 0x01, a write of any data byte to offset 0xC makes `conv_start` high for exactly one clock, in the cycle after the write is sampled, however many cycles `bus_wr` stays high.
- R3: The ready bit is bit 4 of the status byte at offset 0x5. It is 0 after reset, becomes 1 with each accepted start, and returns to 0 in the cycle after `conv_done` is seen during a conversion. It then stays 0 until the next start.
- R4: In mode 0x01, `pacer_tick` starts no conversion.
- R5: In modes 0x06 and 0x02, a `pacer_tick` starts a conversion and a write to offset 0xC starts none.
- R6: In mode 0x06, `irq` rises in the cycle after end-of-conversion and stays high until the host reads offset 0x4.
- R7: In mode 0x02, `dma_req` rises in the cycle after end-of-conversion and falls in the cycle after `dma_ack` is sampled.
- R8: Any mode value other than 0x01, 0x06 or 0x02 starts no conversion. With such a value, `irq` and `dma_req` are low from the second cycle after the mode write onward.
- R9: A start request (host write or pacer tick) that arrives while the ready bit is 1 is ignored.
- R10: A read at offset 0x4 returns `conv_data[7:0]`. A read at offset 0x5 returns {3'b000, ready, `conv_data[11:8]`}. `bus_rdata` holds the value one cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, may be held for several cycles |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pacer_tick | input | 1 | Periodic start request from the pacer timer |
| conv_data | input | 12 | Converter result |
| conv_done | input | 1 | End-of-conversion from the converter |
| conv_start | output | 1 | One-clock start-conversion pulse |
| dma_ack | input | 1 | DMA acknowledge |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Several rules hold on every cycle and are checked continuously: the start pulse is one clock long, every start sets the ready bit, end-of-conversion during a conversion clears it, an acknowledged DMA request falls, and an undefined mode shows no start or request after one settling cycle. Some behaviour only shows in the bench's scenarios. These cases are: whether a trigger write actually fires in the right mode and not in the others, whether pacer ticks are gated per mode, whether starts arriving while the ready bit is 1 are dropped, whether the interrupt survives until the data read, and the exact byte layout of the status and data reads.

// File: rtl/adc_tc_pkg.sv
package adc_tc_pkg;

  localparam logic [7:0] MODE_SW_POLL   = 8'h01;
  localparam logic [7:0] MODE_PACER_IRQ = 8'h06;
  localparam logic [7:0] MODE_PACER_DMA = 8'h02;

  typedef struct packed {
    logic sw_en;
    logic pacer_en;
    logic irq_en;
    logic dma_en;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [7:0] m);
    mode_cfg_t c;
    c = '0;
    case (m)
      MODE_SW_POLL:   c.sw_en = 1'b1;
      MODE_PACER_IRQ: begin c.pacer_en = 1'b1; c.irq_en = 1'b1; end
      MODE_PACER_DMA: begin c.pacer_en = 1'b1; c.dma_en = 1'b1; end
      default:        c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/adc_tc_regs.sv
module adc_tc_regs #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 12,
  parameter int READY_BIT = 4,
  parameter logic [ADDR_W-1:0] OFS_MODE = 'hB,
  parameter logic [ADDR_W-1:0] OFS_TRIG = 'hC,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h5,
  parameter logic [ADDR_W-1:0] OFS_DLO  = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              busy,
  output logic [7:0]        mode_q,
  output logic              sw_trig,
  output logic              data_rd
);
  localparam int HI_W = DATA_W - 8;

  logic trig_hit;
  logic trig_hit_q;
  logic [7:0] stat_byte;
  logic [7:0] rd_mux;

  assign trig_hit = bus_wr && (bus_addr == OFS_TRIG);
  assign sw_trig  = trig_hit && !trig_hit_q;
  assign data_rd  = bus_rd && (bus_addr == OFS_DLO);

  always_comb begin
    stat_byte = '0;
    stat_byte[HI_W-1:0] = conv_data[DATA_W-1:8];
    stat_byte[READY_BIT] = busy;
  end

  always_comb begin
    if (bus_addr == OFS_DLO)       rd_mux = conv_data[7:0];
    else if (bus_addr == OFS_STAT) rd_mux = stat_byte;
    else                           rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      trig_hit_q <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      trig_hit_q <= trig_hit;
      if (bus_wr && (bus_addr == OFS_MODE)) mode_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/adc_tc_trig.sv
module adc_tc_trig (
  input  logic clk,
  input  logic rst,
  input  logic sw_en,
  input  logic pacer_en,
  input  logic sw_trig,
  input  logic pacer_tick,
  input  logic conv_done,
  output logic conv_start,
  output logic busy,
  output logic done_evt
);
  logic req;
  logic accept;

  assign req      = (sw_en && sw_trig) || (pacer_en && pacer_tick);
  assign accept   = req && !busy;
  assign done_evt = busy && conv_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= accept;
      if (accept)        busy <= 1'b1;
      else if (done_evt) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_tc_notify.sv
module adc_tc_notify (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic dma_en,
  input  logic done_evt,
  input  logic data_rd,
  input  logic dma_ack,
  output logic irq,
  output logic dma_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (!irq_en)       irq <= 1'b0;
      else if (done_evt) irq <= 1'b1;
      else if (data_rd)  irq <= 1'b0;

      if (!dma_en)       dma_req <= 1'b0;
      else if (done_evt) dma_req <= 1'b1;
      else if (dma_ack)  dma_req <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_tc_top.sv
module adc_tc_top #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 12,
  parameter int READY_BIT = 4,
  parameter logic [ADDR_W-1:0] OFS_MODE = 'hB,
  parameter logic [ADDR_W-1:0] OFS_TRIG = 'hC,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h5,
  parameter logic [ADDR_W-1:0] OFS_DLO  = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              pacer_tick,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_done,
  output logic              conv_start,
  input  logic              dma_ack,
  output logic              irq,
  output logic              dma_req
);
  import adc_tc_pkg::*;

  logic [7:0] mode_q;
  logic       sw_trig;
  logic       data_rd;
  logic       busy;
  logic       done_evt;
  mode_cfg_t  cfg;

  assign cfg = decode_mode(mode_q);

  adc_tc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READY_BIT(READY_BIT),
    .OFS_MODE(OFS_MODE), .OFS_TRIG(OFS_TRIG),
    .OFS_STAT(OFS_STAT), .OFS_DLO(OFS_DLO)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .conv_data(conv_data), .busy(busy), .mode_q(mode_q),
    .sw_trig(sw_trig), .data_rd(data_rd)
  );

  adc_tc_trig u_trig (
    .clk(clk), .rst(rst), .sw_en(cfg.sw_en), .pacer_en(cfg.pacer_en),
    .sw_trig(sw_trig), .pacer_tick(pacer_tick), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy), .done_evt(done_evt)
  );

  adc_tc_notify u_notify (
    .clk(clk), .rst(rst), .irq_en(cfg.irq_en), .dma_en(cfg.dma_en),
    .done_evt(done_evt), .data_rd(data_rd), .dma_ack(dma_ack),
    .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/adc_tc_chk.sv
module adc_tc_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic       busy,
  input logic       conv_done,
  input logic       irq,
  input logic       dma_req,
  input logic       dma_ack,
  input logic [7:0] mode_q
);
  logic mode_ok;
  assign mode_ok = (mode_q == 8'h01) || (mode_q == 8'h06) || (mode_q == 8'h02);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R2

  AST_START_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy); // R3

  AST_DONE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done) |=> !busy); // R3

  AST_DMA_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_ack && !conv_done) |=> !dma_req); // R7

  AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok && $past(!mode_ok)) |-> (!conv_start && !irq && !dma_req)); // R8
endmodule

bind adc_tc_top adc_tc_chk u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .busy(busy),
  .conv_done(conv_done), .irq(irq), .dma_req(dma_req),
  .dma_ack(dma_ack), .mode_q(mode_q)
);

// File: tb/sim_adc_tc_top.sv
module sim_adc_tc_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       pacer_tick = 1'b0;
  logic [11:0] conv_data = 12'hA5C;
  logic       conv_done = 1'b0;
  logic       conv_start;
  logic       dma_ack = 1'b0;
  logic       irq;
  logic       dma_req;

  int checks = 0;
  int fails = 0;
  int starts = 0;
  bit finished = 1'b0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_tc_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pacer_tick(pacer_tick), .conv_data(conv_data), .conv_done(conv_done),
    .conv_start(conv_start), .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (conv_start) starts++;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R10 unexpected read", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    repeat (len) @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    idle(1);
  endtask

  task automatic tick();
    @(negedge clk); pacer_tick = 1'b1;
    @(negedge clk); pacer_tick = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R3 reset conv_start", conv_start, 0);
    chk("R6 reset irq", irq, 0);
    chk("R7 reset dma_req", dma_req, 0);
    rd(4'h5, 8'h0A, "R3 reset status ready=0");

    // R1/R8: reset mode 0x00 is disabled
    s0 = starts;
    wr(4'hC, 8'h33, 1); idle(2); tick(); idle(2);
    chk("R8 mode 0x00 no start", starts - s0, 0);

    // polled mode
    wr(4'hB, 8'h01, 1);
    s0 = starts;
    wr(4'hC, 8'hFF, 3); idle(2);
    chk("R2 long strobe single pulse", starts - s0, 1);
    rd(4'h5, 8'h1A, "R3 busy after trigger");
    s0 = starts;
    wr(4'hC, 8'h00, 1); idle(2);
    chk("R9 trigger while busy ignored", starts - s0, 0);
    done_pulse();
    rd(4'h5, 8'h0A, "R3 ready cleared after done");
    idle(3);
    rd(4'h5, 8'h0A, "R3 ready stays 0");
    chk("R6 no irq in polled mode", irq, 0);
    chk("R7 no dma in polled mode", dma_req, 0);
    s0 = starts;
    tick(); idle(2);
    chk("R4 pacer ignored in polled mode", starts - s0, 0);
    rd(4'h4, 8'h5C, "R10 low data byte");
    conv_data = 12'h3E7;
    rd(4'h5, 8'h03, "R10 status high nibble");

    // interrupt mode
    wr(4'hB, 8'h06, 1);
    s0 = starts;
    wr(4'hC, 8'h12, 1); idle(2);
    chk("R5 host trigger ignored in irq mode", starts - s0, 0);
    tick(); idle(1);
    chk("R5 pacer starts in irq mode", starts - s0, 1);
    s0 = starts;
    tick(); idle(1);
    chk("R9 pacer while busy ignored", starts - s0, 0);
    done_pulse();
    chk("R6 irq raised on done", irq, 1);
    chk("R7 no dma in irq mode", dma_req, 0);
    idle(4);
    chk("R6 irq held", irq, 1);
    rd(4'h4, 8'hE7, "R10 data read in irq mode");
    chk("R6 irq cleared by data read", irq, 0);

    // DMA mode
    wr(4'hB, 8'h02, 1);
    s0 = starts;
    tick(); idle(1);
    chk("R5 pacer starts in dma mode", starts - s0, 1);
    done_pulse();
    chk("R7 dma_req raised on done", dma_req, 1);
    chk("R6 no irq in dma mode", irq, 0);
    idle(3);
    chk("R7 dma_req held", dma_req, 1);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk("R7 dma_req dropped after ack", dma_req, 0);

    // undefined mode clears pending request and blocks starts
    wr(4'hB, 8'h06, 1);
    tick(); idle(1); done_pulse();
    chk("R6 irq pending before mode change", irq, 1);
    wr(4'hB, 8'h07, 1); idle(1);
    chk("R8 irq dropped in undefined mode", irq, 0);
    s0 = starts;
    tick(); wr(4'hC, 8'h01, 1); idle(2);
    chk("R8 no start in undefined mode", starts - s0, 0);
    chk("R1 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule